// File: doc/BRIEF.md
# Integer to Floating-Point Converter

This block turns a 64-bit integer register operand into a value in binary64 floating-point register format. A 2-bit type code says whether the operand is read as a signed or unsigned number, and whether only the lower half or the full 64 bits are used. A precision select picks one of two forms. The double form rounds to binary64. The single form rounds to binary32 precision and then writes that value widened to binary64 storage format.

A single-cycle combinational datapath does sign handling, leading-zero normalization, rounding in each precision and packing. One register stage follows it and raises a valid strobe one cycle after the request. The status outputs are a 5-bit result class, FR (rounding increased the magnitude) and FI (the result is inexact). The sticky outputs are an inexact bit and a summary exception bit. All status outputs are register-held. A double-form request with a 32-bit source is always exact, so it leaves every status output unchanged.

Top module: `i2f_cvt`

## Requirements
- R1: Type code `type_i` selects the source. 0 is signed 32-bit from `src_i[31:0]`, 1 is unsigned 32-bit from `src_i[31:0]`, 2 is signed 64-bit, 3 is unsigned 64-bit. For the 32-bit types, bits 63..32 have no effect on the result.
- R2: With `single_i`=0 the result is the binary64 encoding of the source, rounded by `rmode_i`. The modes are 00 nearest-even, 01 toward zero, 10 toward +infinity and 11 toward -infinity.
- R3: With `single_i`=1 the source is rounded by `rmode_i` to a 24-bit significand. The result is that binary32 value written as binary64, so the low 29 fraction bits are zero.
- R4: A zero source gives result 0x0000000000000000, FR=0, FI=0 and, on a status-updating request, class 00010.
- R5: The signed 64-bit source 0x8000000000000000 gives exactly 0xC3E0000000000000 in both forms.
- R6: A double-form request with type 0 or 1 leaves `class_o`, `fr_o`, `fi_o`, `xx_o` and `fx_o` unchanged.
- R7: On every other request, FI is loaded with the inexact indication and FR is loaded with 1 exactly when rounding increased the significand magnitude.
- R8: `xx_o` and `fx_o` are both set by an inexact status-updating request. After that they stay set until reset.
- R9: The class code comes from the final value: 00100 for positive normal, 01000 for negative normal, 00010 for positive zero.
- R10: `valid_o` is high in exactly the cycle after a cycle with `valid_i` high. `result_o` changes only after an accepted request.
- R11: During and right after reset, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Request strobe |
| src_i | input | 64 | Integer operand |
| type_i | input | 2 | Bit 0 unsigned, bit 1 full 64-bit width |
| single_i | input | 1 | 1 selects the binary32-precision form |
| rmode_i | input | 2 | Rounding mode |
| valid_o | output | 1 | Result valid, one cycle after request |
| result_o | output | 64 | Result in binary64 format |
| class_o | output | 5 | Result class code |
| fr_o | output | 1 | Rounding increased the magnitude |
| fi_o | output | 1 | Result inexact |
| xx_o | output | 1 | Sticky inexact |
| fx_o | output | 1 | Sticky exception summary |

## Verification
A wrong leading-zero count or a wrong rounding increment shows in `result_o` in the cycle after the request. It shows up most readily at tie values and at the carries that overflow the significand. A status register that updates when it should hold, or fails to update, shows in `class_o`, `fr_o` or `fi_o` at the same point. A sticky bit that is set wrongly or cleared wrongly stays visible at every later request until the next reset, so the bench compares the sticky bits after every operation and not only after inexact ones.

// File: rtl/i2f_pkg.sv
package i2f_pkg;
  localparam int DP_EXP_W  = 11;
  localparam int DP_FRAC_W = 52;
  localparam int SP_EXP_W  = 8;
  localparam int SP_FRAC_W = 23;
  localparam int DP_BIAS   = 1023;
  localparam int SP_BIAS   = 127;

  typedef enum logic [1:0] {
    RND_NEAR_EVEN = 2'b00,
    RND_TO_ZERO   = 2'b01,
    RND_UP        = 2'b10,
    RND_DOWN      = 2'b11
  } rnd_mode_e;

  localparam logic [4:0] CLS_QNAN     = 5'b10001;
  localparam logic [4:0] CLS_NEG_INF  = 5'b01001;
  localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
  localparam logic [4:0] CLS_NEG_DEN  = 5'b11000;
  localparam logic [4:0] CLS_NEG_ZERO = 5'b10010;
  localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
  localparam logic [4:0] CLS_POS_DEN  = 5'b10100;
  localparam logic [4:0] CLS_POS_NORM = 5'b00100;
  localparam logic [4:0] CLS_POS_INF  = 5'b00101;

  function automatic logic [4:0] fp_class(input logic sgn, input logic exp_lo,
                                          input logic exp_hi, input logic frac_nz);
    if (exp_hi) return frac_nz ? CLS_QNAN : (sgn ? CLS_NEG_INF : CLS_POS_INF);
    if (exp_lo) begin
      if (frac_nz) return sgn ? CLS_NEG_DEN : CLS_POS_DEN;
      return sgn ? CLS_NEG_ZERO : CLS_POS_ZERO;
    end
    return sgn ? CLS_NEG_NORM : CLS_POS_NORM;
  endfunction
endpackage

// File: rtl/i2f_unpack.sv
module i2f_unpack #(
  parameter int W = 64
) (
  input  logic [W-1:0] src_i,
  input  logic [1:0]   type_i,
  output logic         sign_o,
  output logic [W-1:0] mag_o
);
  localparam int HW = W / 2;

  logic [W-1:0] wide;

  always_comb begin
    if (type_i[1])      wide = src_i;
    else if (type_i[0]) wide = {{HW{1'b0}}, src_i[HW-1:0]};
    else                wide = {{HW{src_i[HW-1]}}, src_i[HW-1:0]};
    sign_o = ~type_i[0] & wide[W-1];
    // two's-complement negate; most-negative value maps to 2^(W-1) unsigned
    mag_o  = sign_o ? (~wide + W'(1)) : wide;
  end
endmodule

// File: rtl/i2f_lzc.sv
module i2f_lzc #(
  parameter int W   = 64,
  parameter int C_W = $clog2(W + 1)
) (
  input  logic [W-1:0]   val_i,
  output logic [C_W-1:0] cnt_o,
  output logic           zero_o
);
  logic found;

  always_comb begin
    cnt_o = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (!found) begin
        if (val_i[i]) found = 1'b1;
        else          cnt_o = cnt_o + C_W'(1);
      end
    end
    zero_o = ~found;
  end
endmodule

// File: rtl/i2f_round.sv
module i2f_round
  import i2f_pkg::*;
#(
  parameter int W = 64,
  parameter int P = 53
) (
  input  logic [W-1:0] norm_i,
  input  logic         sign_i,
  input  rnd_mode_e    rmode_i,
  output logic [P-1:0] mant_o,
  output logic         carry_o,
  output logic         inexact_o,
  output logic         inc_o
);
  localparam int GB = W - 1 - P;

  logic [P-1:0] keep;
  logic         guard, sticky;
  logic [P:0]   sum;

  always_comb begin
    keep      = norm_i[W-1 -: P];
    guard     = norm_i[GB];
    sticky    = |norm_i[GB-1:0];
    inexact_o = guard | sticky;
    unique case (rmode_i)
      RND_NEAR_EVEN: inc_o = guard & (sticky | keep[0]);
      RND_TO_ZERO:   inc_o = 1'b0;
      RND_UP:        inc_o = ~sign_i & inexact_o;
      RND_DOWN:      inc_o = sign_i & inexact_o;
      default:       inc_o = 1'b0;
    endcase
    sum     = {1'b0, keep} + (P+1)'(inc_o);
    carry_o = sum[P];
    mant_o  = carry_o ? sum[P:1] : sum[P-1:0];
  end
endmodule

// File: rtl/i2f_cvt.sv
module i2f_cvt
  import i2f_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [1:0]        type_i,
  input  logic              single_i,
  input  logic [1:0]        rmode_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic [4:0]        class_o,
  output logic              fr_o,
  output logic              fi_o,
  output logic              xx_o,
  output logic              fx_o
);
  localparam int CNT_W   = $clog2(DATA_W + 1);
  localparam int DP_MANT = DP_FRAC_W + 1;
  localparam int SP_MANT = SP_FRAC_W + 1;
  localparam int N_PREC  = 2;
  localparam int E_W     = DP_EXP_W + 1;

  logic              sign;
  logic [DATA_W-1:0] mag, norm;
  logic [CNT_W-1:0]  lz;
  logic              is_zero;

  i2f_unpack #(.W(DATA_W)) u_unpack (
    .src_i (src_i),
    .type_i(type_i),
    .sign_o(sign),
    .mag_o (mag)
  );

  i2f_lzc #(.W(DATA_W), .C_W(CNT_W)) u_lzc (
    .val_i (mag),
    .cnt_o (lz),
    .zero_o(is_zero)
  );

  assign norm = mag << lz;

  logic [N_PREC-1:0]  carry_v, inexact_v, inc_v;
  logic [DP_MANT-1:0] mant_v [N_PREC];

  // index 0: binary64 precision, index 1: binary32 precision
  for (genvar g = 0; g < N_PREC; g++) begin : g_prec
    localparam int P = (g == 0) ? DP_MANT : SP_MANT;
    logic [P-1:0] mant;
    i2f_round #(.W(DATA_W), .P(P)) u_round (
      .norm_i   (norm),
      .sign_i   (sign),
      .rmode_i  (rnd_mode_e'(rmode_i)),
      .mant_o   (mant),
      .carry_o  (carry_v[g]),
      .inexact_o(inexact_v[g]),
      .inc_o    (inc_v[g])
    );
    assign mant_v[g] = DP_MANT'(mant) << (DP_MANT - P);
  end

  logic               sel, carry, inexact, inc, upd;
  logic [DP_MANT-1:0] mant;
  logic [E_W-1:0]     e_unb;
  logic [DP_EXP_W-1:0] exp_dp;
  logic [SP_EXP_W-1:0] exp_sp;
  logic               exp_hi;
  logic [DATA_W-1:0]  res_d;
  logic [4:0]         cls_d;

  always_comb begin
    sel     = single_i;
    carry   = carry_v[sel];
    inexact = inexact_v[sel];
    inc     = inc_v[sel];
    mant    = mant_v[sel];
    e_unb   = E_W'(DATA_W - 1) - E_W'(lz) + E_W'(carry);
    exp_dp  = DP_EXP_W'(e_unb + E_W'(DP_BIAS));
    exp_sp  = SP_EXP_W'(e_unb + E_W'(SP_BIAS));
    exp_hi  = sel ? (&exp_sp) : (&exp_dp);
    res_d   = is_zero ? '0 : {sign, exp_dp, mant[DP_FRAC_W-1:0]};
    cls_d   = fp_class(sign, is_zero, exp_hi, |mant[DP_FRAC_W-1:0]);
    // 32-bit source into binary64 is exact by construction: status untouched
    upd     = single_i | type_i[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o  <= 1'b0;
      result_o <= '0;
      class_o  <= '0;
      fr_o     <= 1'b0;
      fi_o     <= 1'b0;
      xx_o     <= 1'b0;
      fx_o     <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        if (upd) begin
          class_o <= cls_d;
          fr_o    <= inc;
          fi_o    <= inexact;
          if (inexact) begin
            xx_o <= 1'b1;
            fx_o <= 1'b1;
          end
        end
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R10
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R10
  AST_RESULT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o)); // R10
  AST_EXACT_KEEPS_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !single_i && !type_i[1]) |=>
      ($stable(class_o) && $stable(fr_o) && $stable(fi_o) && $stable(xx_o) && $stable(fx_o))); // R6
  AST_FR_NEEDS_FI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fr_o |-> fi_o); // R7
  AST_XX_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xx_o |=> xx_o); // R8
  AST_FX_WITH_XX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fx_o |-> xx_o); // R8
  AST_SP_LOW_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && single_i) |=> (result_o[28:0] == 29'd0)); // R3
endmodule

// File: tb/i2f_cvt_tb_top.sv
`timescale 1ns/1ps
module i2f_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [63:0] src = '0;
  logic [1:0]  typ = '0;
  logic        sgl = 1'b0;
  logic [1:0]  rm = '0;
  logic        valid_o;
  logic [63:0] result_o;
  logic [4:0]  class_o;
  logic        fr_o, fi_o, xx_o, fx_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [4:0] e_cls;
  logic       e_fr, e_fi, e_xx, e_fx;

  always #10 clk = ~clk;

  i2f_cvt dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .src_i(src), .type_i(typ),
    .single_i(sgl), .rmode_i(rm), .valid_o(valid_o), .result_o(result_o),
    .class_o(class_o), .fr_o(fr_o), .fi_o(fi_o), .xx_o(xx_o), .fx_o(fx_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // reference: arithmetic rounding by remainder comparison
  task automatic model(input logic [63:0] s, input logic [1:0] t, input logic sg,
                       input logic [1:0] r, output logic [63:0] res,
                       output logic [4:0] cls, output logic fr, output logic fi);
    logic [63:0] v, mag, q, rem, half;
    logic neg, up;
    int k, p, sh;
    case (t)
      2'd0: v = {{32{s[31]}}, s[31:0]};
      2'd1: v = {32'd0, s[31:0]};
      default: v = s;
    endcase
    neg = (t[0] == 1'b0) && v[63];
    mag = neg ? (64'd0 - v) : v;
    fr = 1'b0; fi = 1'b0;
    if (mag == 0) begin
      res = '0; cls = 5'b00010;
      return;
    end
    k = 0;
    for (int i = 63; i >= 0; i--) if (mag[i]) begin k = i; break; end
    p = sg ? 24 : 53;
    if (k < p) begin
      q = mag << (p - 1 - k);
    end else begin
      sh   = k - (p - 1);
      q    = mag >> sh;
      rem  = mag - (q << sh);
      half = 64'd1 << (sh - 1);
      fi   = (rem != 0);
      case (r)
        2'b00: up = (rem > half) || (rem == half && q[0]);
        2'b01: up = 1'b0;
        2'b10: up = !neg && fi;
        default: up = neg && fi;
      endcase
      fr = up;
      q = q + (up ? 64'd1 : 64'd0);
      if (q == (64'd1 << p)) begin q = q >> 1; k++; end
    end
    res = {neg, 11'(k + 1023), sg ? {q[22:0], 29'd0} : q[51:0]};
    cls = neg ? 5'b01000 : 5'b00100;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; valid = 1'b0;
    @(negedge clk);
    chk("R11 valid", 64'(valid_o), 0);
    chk("R11 result", result_o, 0);
    chk("R11 class", 64'(class_o), 0);
    chk("R11 flags", {60'd0, fr_o, fi_o, xx_o, fx_o}, 0);
    rst_n = 1'b1;
    e_cls = '0; e_fr = 0; e_fi = 0; e_xx = 0; e_fx = 0;
  endtask

  task automatic do_op(input logic [63:0] s, input logic [1:0] t, input logic sg,
                       input logic [1:0] r, input string tag);
    logic [63:0] er;
    logic [4:0] c;
    logic f_r, f_i;
    model(s, t, sg, r, er, c, f_r, f_i);
    @(negedge clk);
    src = s; typ = t; sgl = sg; rm = r; valid = 1'b1;
    @(negedge clk);
    valid = 1'b0;
    if (sg || t[1]) begin
      e_cls = c; e_fr = f_r; e_fi = f_i;
      if (f_i) begin e_xx = 1'b1; e_fx = 1'b1; end
    end
    chk("R10 valid_o", 64'(valid_o), 1);
    chk(tag, result_o, er);
    chk((sg || t[1]) ? "R9 class" : "R6 class", 64'(class_o), 64'(e_cls));
    chk((sg || t[1]) ? "R7 fr" : "R6 fr", 64'(fr_o), 64'(e_fr));
    chk((sg || t[1]) ? "R7 fi" : "R6 fi", 64'(fi_o), 64'(e_fi));
    chk("R8 xx", 64'(xx_o), 64'(e_xx));
    chk("R8 fx", 64'(fx_o), 64'(e_fx));
  endtask

  function automatic logic [63:0] pat(input int i);
    case (i)
      0: return 64'd0;
      1: return 64'd1;
      2: return 64'd3;
      3: return 64'hFFFF_FFFF_FFFF_FFFF;
      4: return 64'hFFFF_FFFF_FFFF_FFFE;
      5: return 64'h0000_0000_7FFF_FFFF;
      6: return 64'h0000_0000_8000_0000;
      7: return 64'h0000_0000_FFFF_FFFF;
      8: return 64'h0000_0000_0100_0001;
      9: return 64'h0000_0000_0100_0003;
      10: return 64'h0000_0000_0180_0001;
      11: return 64'h7FFF_FFFF_FFFF_FFFF;
      12: return 64'h8000_0000_0000_0000;
      13: return 64'h0020_0000_0000_0001;
      14: return 64'h0020_0000_0000_0003;
      15: return 64'h0020_0000_0000_0002;
      16: return 64'hFFDF_FFFF_FFFF_FFFF;
      17: return 64'h8000_0000_0000_0400;
      18: return 64'hABCD_0000_FEFF_FFFF;
      default: return 64'd0;
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] x;
    logic [63:0] held;
    e_cls = '0; e_fr = 0; e_fi = 0; e_xx = 0; e_fx = 0;
    do_reset();
    // R1: upper half ignored for 32-bit types
    do_op(64'hDEAD_BEEF_FFFF_FFFF, 2'd0, 1'b0, 2'b00, "R1 s32");
    chk("R1 s32 value", result_o, 64'hBFF0_0000_0000_0000);
    do_op(64'h1234_5678_FFFF_FFFF, 2'd1, 1'b0, 2'b00, "R1 u32");
    chk("R1 u32 value", result_o, 64'h41EF_FFFF_FFE0_0000);
    // R4 zero
    do_op(64'd0, 2'd2, 1'b0, 2'b10, "R4 zero");
    chk("R4 zero class", 64'(class_o), 64'h2);
    // R5 most negative
    do_op(64'h8000_0000_0000_0000, 2'd2, 1'b0, 2'b00, "R5 dp");
    chk("R5 dp value", result_o, 64'hC3E0_0000_0000_0000);
    do_op(64'h8000_0000_0000_0000, 2'd2, 1'b1, 2'b11, "R5 sp");
    chk("R5 sp value", result_o, 64'hC3E0_0000_0000_0000);
    chk("R5 exact", 64'(fi_o), 0);
    // R10: idle cycle holds result, drops valid
    held = result_o;
    @(negedge clk);
    chk("R10 idle valid", 64'(valid_o), 0);
    chk("R10 idle hold", result_o, held);
    // sweep: fixed patterns then pseudo-random
    x = 64'h9E37_79B9_7F4A_7C15;
    for (int i = 0; i < 64; i++) begin
      logic [63:0] v;
      if (i < 19) v = pat(i);
      else begin
        x = x ^ (x << 13); x = x ^ (x >> 7); x = x ^ (x << 17);
        v = (i % 3 == 0) ? (x >> (i % 40)) : x;
      end
      for (int t = 0; t < 4; t++)
        for (int s = 0; s < 2; s++)
          for (int r = 0; r < 4; r++)
            do_op(v, 2'(t), 1'(s), 2'(r), s ? "R3 sp result" : "R2 dp result");
    end
    // R8: reset clears sticky, inexact sets, exact op keeps
    do_reset();
    do_op(64'h0020_0000_0000_0001, 2'd3, 1'b0, 2'b01, "R8 inexact");
    chk("R8 set", 64'(xx_o), 1);
    do_op(64'd5, 2'd2, 1'b0, 2'b00, "R8 exact after");
    chk("R8 stays", 64'(fx_o), 1);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule